// File: doc/BRIEF.md
# Serial Frame Transmitter with Collision Abort

This block turns a parallel data word into an asynchronous serial frame on a single line. Time is measured in quanta: an external tick marks each quantum, and every bit lasts a programmable number of quanta. A frame is a low start bit, the data bits least significant first, an optional even parity bit, and one or two high stop bits. For infrared-style links, zero bits can be cut to a short low pulse followed by a high level for the rest of the bit.

The transmitter also reads back the line it drives. When collision checking is on, it compares the read-back level with its own level once per bit, at a programmable quantum. On a mismatch it abandons the frame, returns the line high, raises a sticky collision flag and pulses a protocol interrupt. It starts no further frame until software clears the flag. A status flag can follow frame activity, and an optional one-cycle pulse reports each completed frame.

Top module: `ser_tx_cd`

## Requirements
- R1: A frame is sent as start bit 0 at bit index 0, then data bit 0 up to data bit DATA_W-1, then, when parity_en_i is 1, an even parity bit (XOR of the data bits), then the stop bits at level 1. Each bit lasts quanta_m1_i+1 quanta.
- R2: two_stop_i, captured when the frame starts, selects two stop bits when 1 and one stop bit when 0.
- R3: With pulse_len_i = 0 a zero bit is low for the whole bit. With pulse_len_i = N > 0 a zero bit is low in quanta 0..N of the bit and high after that. Bits at level 1 are high for the whole bit.
- R4: The line is high whenever no frame is in progress. A start_i pulse while idle begins the frame in the next cycle, and start_i during a frame has no effect on it.
- R5: With coll_en_i = 1, a tick in quantum sample_pt_i of any bit where rxd_i differs from txd_o ends the frame. In the next cycle txd_o is 1, coll_o is 1 and proto_irq_o is high for exactly one cycle.
- R6: With coll_en_i = 0 a mismatch between rxd_i and txd_o never interrupts the frame.
- R7: While coll_o is 1, start_i is refused and the line stays high. A coll_i-clear pulse (coll_clr_i) drops coll_o in the next cycle, after which frames start again.
- R8: With stat_en_i = 1, status_o is 1 from the first cycle of a frame until the frame ends or is aborted. With stat_en_i = 0, frame activity leaves status_o unchanged.
- R9: fin_o is high for one cycle, in the cycle right after the last quantum of the last stop bit, only when fin_ie_i is 1. An aborted frame gives no fin_o.
- R10: The quantum count advances only on cycles where tq_tick_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tq_tick_i | input | 1 | One-cycle time-quantum tick |
| quanta_m1_i | input | QW | Quanta per bit minus one |
| sample_pt_i | input | QW | Quantum index at which the read-back line is compared |
| pulse_len_i | input | PLW | Zero-bit pulse length code (0 = full bit) |
| parity_en_i | input | 1 | Append even parity |
| two_stop_i | input | 1 | Two stop bits when 1 |
| coll_en_i | input | 1 | Enable collision checking |
| stat_en_i | input | 1 | Let frame activity drive status_o |
| fin_ie_i | input | 1 | Enable the frame-finished pulse |
| start_i | input | 1 | Request to send data_i |
| data_i | input | DATA_W | Word to send |
| coll_clr_i | input | 1 | Clears the collision flag |
| rxd_i | input | 1 | Read-back of the serial line |
| txd_o | output | 1 | Serial line |
| status_o | output | 1 | Frame-in-progress status |
| coll_o | output | 1 | Sticky collision flag |
| fin_o | output | 1 | Frame-finished pulse |
| proto_irq_o | output | 1 | Collision interrupt pulse |

## Verification
The hard case is a collision: the line the block reads normally matches what it drives, so a mismatch only arises when the bench breaks the loop. The bench feeds rxd_i from txd_o and, for chosen frames, inverts the path. With checking enabled this forces an abort at a known sample quantum and then a refused start while locked. With checking disabled it confirms that the frame runs to the end untouched. Each frame's expected line level is also compared quantum by quantum, with parity, two stop bits and several pulse lengths.

// File: rtl/tx_cd_pkg.sv
package tx_cd_pkg;
  typedef struct packed {
    logic par_en;
    logic two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/tx_quanta_timer.sv
module tx_quanta_timer #(
  parameter int QW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [QW-1:0] qm1_i,
  output logic [QW-1:0] q_o,
  output logic          bit_end_o
);
  logic [QW-1:0] q_q;

  assign bit_end_o = run_i & tick_i & (q_q == qm1_i);
  assign q_o       = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_q <= '0;
    else if (!run_i)    q_q <= '0;
    else if (bit_end_o) q_q <= '0;
    else if (tick_i)    q_q <= q_q + 1'b1;
  end

  p_hold_no_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> (q_q == $past(q_q) || !$past(run_i)) || !run_i);
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import tx_cd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  frame_cfg_t        cfg_i,
  input  logic              bit_end_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              lvl_o,
  output logic              done_o
);
  localparam int FW    = DATA_W + 4;
  localparam int IDX_W = $clog2(FW);

  logic [FW-1:0]    frame_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign lvl_o  = frame_q[idx_q];
  assign done_o = busy_q & bit_end_i & (idx_q == last_q) & ~abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      idx_q   <= '0;
      last_q  <= '0;
      busy_q  <= 1'b0;
    end else if (load_i) begin
      frame_q <= {2'b11, (cfg_i.par_en ? ^data_i : 1'b1), data_i, 1'b0};
      idx_q   <= '0;
      last_q  <= IDX_W'(DATA_W) + IDX_W'(cfg_i.par_en) + (cfg_i.two_stop ? IDX_W'(2) : IDX_W'(1));
      busy_q  <= 1'b1;
    end else if (abort_i || done_o) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
    end else if (busy_q && bit_end_i) begin
      idx_q   <= idx_q + 1'b1;
    end
  end

  p_start_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (busy_o && !lvl_o));
  p_done_ends_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/tx_line_shaper.sv
module tx_line_shaper #(
  parameter int QW  = 5,
  parameter int PLW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           busy_i,
  input  logic           lvl_i,
  input  logic [QW-1:0]  q_i,
  input  logic [PLW-1:0] pl_i,
  input  logic [QW-1:0]  sample_pt_i,
  input  logic           tick_i,
  input  logic           rxd_i,
  input  logic           coll_en_i,
  output logic           txd_o,
  output logic           coll_hit_o
);
  localparam int CW = (QW > PLW) ? QW : PLW;

  logic short_hi;
  assign short_hi = (pl_i != '0) && (CW'(q_i) > CW'(pl_i));

  always_comb begin
    if (!busy_i)     txd_o = 1'b1;
    else if (lvl_i)  txd_o = 1'b1;
    else             txd_o = short_hi;
  end

  assign coll_hit_o = coll_en_i & busy_i & tick_i & (q_i == sample_pt_i) & (rxd_i != txd_o);

  p_one_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && lvl_i) |-> txd_o);
  p_idle_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> txd_o);
  p_zero_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !lvl_i && pl_i == '0) |-> !txd_o);
endmodule

// File: rtl/ser_tx_cd.sv
module ser_tx_cd
  import tx_cd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int QW     = 5,
  parameter int PLW    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tq_tick_i,
  input  logic [QW-1:0]     quanta_m1_i,
  input  logic [QW-1:0]     sample_pt_i,
  input  logic [PLW-1:0]    pulse_len_i,
  input  logic              parity_en_i,
  input  logic              two_stop_i,
  input  logic              coll_en_i,
  input  logic              stat_en_i,
  input  logic              fin_ie_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              coll_clr_i,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              status_o,
  output logic              coll_o,
  output logic              fin_o,
  output logic              proto_irq_o
);
  logic          busy, lvl, done, bit_end, coll_hit, load;
  logic [QW-1:0] q;
  logic          coll_q, stat_q, fin_q, irq_q;
  frame_cfg_t    cfg;

  assign cfg  = '{par_en: parity_en_i, two_stop: two_stop_i};
  assign load = start_i & ~busy & ~coll_q;

  tx_quanta_timer #(.QW(QW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy), .tick_i(tq_tick_i),
    .qm1_i(quanta_m1_i), .q_o(q), .bit_end_o(bit_end)
  );

  tx_frame_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .data_i(data_i), .cfg_i(cfg),
    .bit_end_i(bit_end), .abort_i(coll_hit), .busy_o(busy), .lvl_o(lvl), .done_o(done)
  );

  tx_line_shaper #(.QW(QW), .PLW(PLW)) u_shape (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .lvl_i(lvl), .q_i(q),
    .pl_i(pulse_len_i), .sample_pt_i(sample_pt_i), .tick_i(tq_tick_i),
    .rxd_i(rxd_i), .coll_en_i(coll_en_i), .txd_o(txd_o), .coll_hit_o(coll_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coll_q <= 1'b0;
      stat_q <= 1'b0;
      fin_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= coll_hit;
      fin_q <= done & fin_ie_i;
      if (coll_hit)        coll_q <= 1'b1;
      else if (coll_clr_i) coll_q <= 1'b0;
      if (stat_en_i) begin
        if (load)                  stat_q <= 1'b1;
        else if (done || coll_hit) stat_q <= 1'b0;
      end
    end
  end

  assign status_o    = stat_q;
  assign coll_o      = coll_q;
  assign fin_o       = fin_q;
  assign proto_irq_o = irq_q;

  p_coll_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coll_o) |-> (proto_irq_o && txd_o));
  p_irq_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_irq_o |=> !proto_irq_o);
  p_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_o && !busy) |=> !busy);
  p_fin_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> ($past(fin_ie_i) && !busy));
  p_stat_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_en_i && $past(stat_en_i) && busy) |-> status_o);
endmodule

// File: tb/ser_tx_cd_bench.sv
`timescale 1ns/1ps
module ser_tx_cd_bench;
  localparam int DATA_W = 8;
  localparam int QW     = 5;
  localparam int PLW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [QW-1:0] qm1 = 5'd3, sp = 5'd1;
  logic [PLW-1:0] pl = '0;
  logic par_en = 0, two_stop = 0, coll_en = 0, stat_en = 0, fin_ie = 0;
  logic start = 0, coll_clr = 0, inj = 0;
  logic [DATA_W-1:0] data = '0;
  logic rxd, txd, status, coll, fin, irq;

  int n_chk = 0, n_bad = 0;
  logic [2:0] sb_q[$];   // {txd, fin, status}

  always #2.5 clk = ~clk;
  assign rxd = inj ? ~txd : txd;

  ser_tx_cd #(.DATA_W(DATA_W), .QW(QW), .PLW(PLW)) u_ser_tx_cd (
    .clk_i(clk), .rst_ni(rst_n), .tq_tick_i(tick), .quanta_m1_i(qm1),
    .sample_pt_i(sp), .pulse_len_i(pl), .parity_en_i(par_en), .two_stop_i(two_stop),
    .coll_en_i(coll_en), .stat_en_i(stat_en), .fin_ie_i(fin_ie), .start_i(start),
    .data_i(data), .coll_clr_i(coll_clr), .rxd_i(rxd), .txd_o(txd),
    .status_o(status), .coll_o(coll), .fin_o(fin), .proto_irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: one expected item per cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      logic [2:0] e;
      e = sb_q.pop_front();
      chk({txd, fin, status} == e, "R1 R2 R3 R8 R9 line/fin/status", {txd, fin, status}, e);
    end
  end

  // driver: start a frame and queue its expected per-quantum levels
  task automatic send(input logic [DATA_W-1:0] d, input int q, input int p,
                      input bit pe, input bit ts, input bit se, input bit fe, input bit poke);
    bit bits[$];
    @(negedge clk);
    qm1 = QW'(q - 1); pl = PLW'(p); par_en = pe; two_stop = ts;
    stat_en = se; fin_ie = fe; data = d; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    bits.push_back(1'b0);
    for (int i = 0; i < DATA_W; i++) bits.push_back(d[i]);
    if (pe) bits.push_back(^d);
    bits.push_back(1'b1);
    if (ts) bits.push_back(1'b1);
    foreach (bits[b])
      for (int k = 0; k < q; k++) begin
        bit lv;
        lv = bits[b] ? 1'b1 : ((p == 0) ? 1'b0 : (k > p));
        sb_q.push_back({lv, 1'b0, se});
      end
    sb_q.push_back({1'b1, fe, 1'b0});
    sb_q.push_back({1'b1, 1'b0, 1'b0});
    if (poke) begin  // R4: start during frame must not disturb it
      repeat (5) @(negedge clk);
      data = ~d; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({txd, status, coll, fin, irq} == 5'b10000, "reset R4", {txd, status, coll, fin, irq}, 5'b10000);

    // R1 R3 R4 R8 R9: no parity, one stop, full zeros, poke start mid-frame
    send(8'hA5, 4, 0, 0, 0, 1, 1, 1);
    // R1 R2 R3 R9: parity, two stops, short zeros, fin disabled, status disabled
    send(8'h3C, 8, 2, 1, 1, 0, 0, 0);
    // R6: inverted read-back with checking off; R3 longest pulse
    coll_en = 0; inj = 1;
    send(8'h81, 16, 7, 1, 0, 1, 1, 0);
    inj = 0;

    // R5 collision abort
    @(negedge clk);
    qm1 = 5'd7; sp = 5'd3; pl = '0; coll_en = 1; stat_en = 1; fin_ie = 1;
    par_en = 0; two_stop = 0; data = 8'h00; inj = 1; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(txd == 1'b0 && coll == 1'b0, "R5 before sample", {txd, coll}, 2'b00);
    end
    @(negedge clk);
    chk({txd, coll, irq, status, fin} == 5'b11100, "R5 abort", {txd, coll, irq, status, fin}, 5'b11100);
    @(negedge clk);
    chk(irq == 1'b0, "R5 irq one cycle", irq, 0);
    inj = 0;
    // R7 start refused while locked
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk({txd, status, coll} == 3'b101, "R7 locked", {txd, status, coll}, 3'b101);
    end
    coll_clr = 1'b1;
    @(negedge clk); coll_clr = 1'b0;
    chk(coll == 1'b0, "R7 clear", coll, 0);

    // R5 negative + R10-style restart after clear: checking on, matching read-back
    send(8'hFF, 5, 1, 0, 1, 1, 1, 0);
    send(8'h5A, 3, 1, 1, 0, 1, 1, 0);
    chk(coll == 1'b0, "R5 no false collision", coll, 0);

    // R10: quantum count holds without ticks
    @(negedge clk);
    qm1 = 5'd1; pl = '0; data = 8'hFF; start = 1'b1; tick = 1'b0;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    chk(txd == 1'b0, "R10 start bit held without tick", txd, 0);
    tick = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R10 first quantum", txd, 0);
    @(negedge clk);
    chk(txd == 1'b1, "R10 advanced to data", txd, 1);
    repeat (40) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule